// File: doc/BRIEF.md
# I2C Channel Select Register Target

This block is an I2C target that holds one control byte. The byte chooses which of two downstream bus channels a separate switch fabric connects to the upstream bus. The block oversamples SCL and SDA on a fast system clock and finds START and STOP conditions. It receives the 7-bit address and the R/W bit. It acknowledges its own address and every data byte written to it. It drives SDA only as an open-drain pull-down.

A write transfer stores the last byte received. The channel-enable outputs take the new selection only when the bus master ends the transfer with STOP. A repeated START does not commit the selection. A read returns the stored channel bits in the low nibble, the live state of the two interrupt inputs in bits 5 and 4, and zeros in bits 7 and 6. The master reads the status after the block's interrupt lines signal an event, then selects the channel that raised it.

Top module: `chansel_i2c_target`

## Requirements
- R1: While `rst` is high, the block clears the stored byte to zero, drives `chan_en` to 00 and releases SDA (`sda_drive_low` = 0). After reset, a read returns 0x00 when no interrupt is asserted.
- R2: The target address is `{ADDR_BASE[6:2], addr_strap[1:0]}` (0x72 when the straps are 10, 0x71 when they are 01). Bit 0 of the address byte selects read (1) or write (0). On a match the block holds SDA low for the whole ninth SCL high phase.
- R3: After an address that does not match, the block does not acknowledge and ignores every bit until the next START. Data that follows leaves the stored byte and `chan_en` unchanged and gets no acknowledge.
- R4: Each data byte of a write is acknowledged. When one transfer carries several bytes, only the last one is kept.
- R5: `chan_en[0]` enables channel 0 and `chan_en[1]` enables channel 1. Both may be high together, and 00 connects no channel. `chan_en` changes only at a detected STOP, never at the end of a data byte.
- R6: A read returns a byte with bits 7:6 = 00, bit 5 = 1 when `irq_n[1]` is low, bit 4 = 1 when `irq_n[0]` is low, and bits 3:0 equal to bits 3:0 of the last byte written.
- R7: While the master acknowledges, the read continues with a freshly sampled status byte. After a master NACK the block releases SDA so that the master can issue STOP.
- R8: A repeated START abandons any partly received byte and restarts address reception. A byte written before the repeated START is stored, and a read returns it, but `chan_en` keeps its old value until STOP.
- R9: The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw upstream SCL level |
| sda_i | input | 1 | Raw upstream SDA level (wired bus value) |
| addr_strap | input | STRAP_W | Low address bits taken from board straps |
| irq_n | input | NUM_CHAN | Synchronized active-low interrupt level per channel |
| sda_drive_low | output | 1 | 1 = pull SDA low, 0 = release SDA |
| chan_en | output | NUM_CHAN | Committed channel enables for the switch fabric |

## Verification
Most faults in the bit engine show up on SDA within one SCL period. A wrong bit count or state moves the acknowledge pull-down out of the ninth clock, or leaves it asserted into the next byte. A corrupted shift register shows up in the first read-back, because bits 7:4 of that byte come from known sources. A commit path that fires early shows up on `chan_en` at the data acknowledge, before STOP. A commit path that misses STOP shows up one bus transaction later, when the enables fail to follow the written byte.

// File: rtl/chansel_pkg.sv
package chansel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_ACK   = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4,
    ST_RACK  = 3'd5
  } tgt_state_t;

endpackage

// File: rtl/chansel_line_sync.sv
module chansel_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_chain[0] <= 1'b1;
            sda_chain[0] <= 1'b1;
          end else begin
            scl_chain[0] <= scl_i;
            sda_chain[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_chain[STAGES-1];
      sda_q <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/chansel_bit_engine.sv
module chansel_bit_engine
  import chansel_pkg::*;
#(
  parameter int         BYTE_W    = 8,
  parameter int         STRAP_W   = 2,
  parameter int         WR_W      = 4,
  parameter logic [6:0] ADDR_BASE = 7'h70
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_low,
  output logic               wr_stb,
  output logic [WR_W-1:0]    wr_data,
  output logic               idle
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  tgt_state_t        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic              sda_low_q;
  logic              wr_stb_q;
  logic              addr_hit;

  assign addr_hit = (shreg_q[BYTE_W-1:1] == {ADDR_BASE[6:STRAP_W], addr_strap});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      sda_low_q <= 1'b0;
      wr_stb_q  <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_low_q <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        sda_low_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt_q != LAST_BIT) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + ONE;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_low_q <= 1'b1;
                  rw_q      <= shreg_q[0];
                  state_q   <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                wr_stb_q  <= 1'b1;
                sda_low_q <= 1'b1;
                state_q   <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_q      <= rd_byte;
                sda_low_q <= ~rd_byte[BYTE_W-1];
                bit_cnt_q <= ONE;
                state_q   <= ST_RDATA;
              end else begin
                sda_low_q <= 1'b0;
                bit_cnt_q <= '0;
                state_q   <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt_q == LAST_BIT) begin
                sda_low_q <= 1'b0;
                state_q   <= ST_RACK;
              end else begin
                sda_low_q <= ~tx_q[BYTE_W-2];
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + ONE;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_s) begin
              state_q <= ST_IDLE;
            end else if (scl_fall) begin
              tx_q      <= rd_byte;
              sda_low_q <= ~rd_byte[BYTE_W-1];
              bit_cnt_q <= ONE;
              state_q   <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low = sda_low_q;
  assign wr_stb  = wr_stb_q;
  assign wr_data = shreg_q[WR_W-1:0];
  assign idle    = (state_q == ST_IDLE);

endmodule

// File: rtl/chansel_ctrl_reg.sv
module chansel_ctrl_reg #(
  parameter int BYTE_W   = 8,
  parameter int NUM_CHAN = 2,
  parameter int STORE_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [STORE_W-1:0]  wr_data,
  input  logic                stop_det,
  input  logic [NUM_CHAN-1:0] irq_n,
  output logic [BYTE_W-1:0]   rd_byte,
  output logic [NUM_CHAN-1:0] chan_en
);

  logic [STORE_W-1:0]  ctrl_q;
  logic [NUM_CHAN-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      chan_q <= '0;
    end else begin
      if (wr_stb) begin
        ctrl_q <= wr_data;
      end
      if (stop_det) begin
        chan_q <= ctrl_q[NUM_CHAN-1:0];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    rd_byte[STORE_W-1:0] = ctrl_q;
    rd_byte[STORE_W +: NUM_CHAN] = ~irq_n;
  end

  assign chan_en = chan_q;

endmodule

// File: rtl/chansel_i2c_target.sv
module chansel_i2c_target #(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_CHAN    = 2,
  parameter int         STRAP_W     = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h70
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [STRAP_W-1:0]  addr_strap,
  input  logic [NUM_CHAN-1:0] irq_n,
  output logic                sda_drive_low,
  output logic [NUM_CHAN-1:0] chan_en
);

  localparam int BYTE_W  = 8;
  localparam int STORE_W = 2 * NUM_CHAN;

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_stb;
  logic [STORE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_byte;
  logic              eng_idle;

  chansel_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  chansel_bit_engine #(
    .BYTE_W    (BYTE_W),
    .STRAP_W   (STRAP_W),
    .WR_W      (STORE_W),
    .ADDR_BASE (ADDR_BASE)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .addr_strap (addr_strap),
    .rd_byte    (rd_byte),
    .sda_low    (sda_drive_low),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .idle       (eng_idle)
  );

  chansel_ctrl_reg #(
    .BYTE_W   (BYTE_W),
    .NUM_CHAN (NUM_CHAN),
    .STORE_W  (STORE_W)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .stop_det (stop_det),
    .irq_n    (irq_n),
    .rd_byte  (rd_byte),
    .chan_en  (chan_en)
  );

endmodule

// File: rtl/chansel_i2c_target_chk.sv
module chansel_i2c_target_chk #(
  parameter int NUM_CHAN = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_s,
  input logic                stop_det,
  input logic                eng_idle,
  input logic                sda_drive_low,
  input logic [NUM_CHAN-1:0] chan_en
);

  // R1: leaving reset, enables are cleared and SDA is released
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chan_en == '0 && !sda_drive_low));

  // R5: enables move only in the cycle after a detected STOP
  assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_en) |-> $past(stop_det));

  // R9: the pull-down holds steady while sampled SCL stays high
  assert_drive_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_drive_low));

  // R3: an idle target never pulls SDA
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    eng_idle |-> !sda_drive_low);

endmodule

bind chansel_i2c_target chansel_i2c_target_chk #(
  .NUM_CHAN (NUM_CHAN)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_s         (scl_s),
  .stop_det      (stop_det),
  .eng_idle      (eng_idle),
  .sda_drive_low (sda_drive_low),
  .chan_en       (chan_en)
);

// File: tb/chansel_i2c_target_bench.sv
module chansel_i2c_target_bench;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [1:0] irq_n = 2'b11;
  logic       drive;
  logic [1:0] chan_en;
  logic       sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~drive;

  chansel_i2c_target u_chansel_i2c_target (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .addr_strap    (strap),
    .irq_n         (irq_n),
    .sda_drive_low (drive),
    .chan_en       (chan_en)
  );

  // vector fields: {address[6:0], data[7:0], expect_ack, expect_chan[1:0]}
  localparam logic [17:0] VEC [6] = '{
    {7'h72, 8'h01, 1'b1, 2'b01},
    {7'h72, 8'h03, 1'b1, 2'b11},
    {7'h72, 8'hF2, 1'b1, 2'b10},
    {7'h73, 8'h01, 1'b0, 2'b10},
    {7'h52, 8'h03, 1'b0, 2'b10},
    {7'h72, 8'h00, 1'b1, 2'b00}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // sends a byte, checks the ninth-clock acknowledge and its stability (R9)
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack_mid;
    logic ack_end;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2);
    ack_mid = ~sda_line;
    tick(Q - 4);
    ack_end = ~sda_line;
    tick(2);
    scl_m = 1'b0; tick(Q);
    chk(req, {7'd0, ack_mid}, {7'd0, exp_ack});
    chk("R9 ack held over SCL high", {7'd0, ack_end}, {7'd0, ack_mid});
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      b[i] = sda_line;
      tick(Q / 2);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~m_ack; tick(Q);
    scl_m = 1'b1;   tick(Q);
    scl_m = 1'b0;   tick(Q);
    sda_m = 1'b1;
  endtask

  logic [7:0] rb;

  initial begin
    tick(10);
    chk("R1 chan_en in reset", {6'd0, chan_en}, 8'h00);
    chk("R1 sda released in reset", {7'd0, drive}, 8'h00);
    rst = 1'b0;
    tick(10);

    // table: R2 address match, R3 mismatch ignored, R4 write, R5 enables
    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte({VEC[v][17:11], 1'b0}, VEC[v][2], "R2/R3 address ack");
      send_byte(VEC[v][10:3], VEC[v][2], "R4/R3 data ack");
      bus_stop();
      tick(5);
      chk("R5 chan_en after STOP", {6'd0, chan_en}, {6'd0, VEC[v][1:0]});
    end

    // R4 last byte kept, R5 no change before STOP
    bus_start();
    send_byte(8'hE4, 1'b1, "R2 address ack");
    send_byte(8'h03, 1'b1, "R4 first byte ack");
    send_byte(8'h02, 1'b1, "R4 second byte ack");
    chk("R5 chan_en held before STOP", {6'd0, chan_en}, 8'h00);
    bus_stop();
    tick(5);
    chk("R4 last byte committed", {6'd0, chan_en}, 8'h02);

    // R8 repeated START: stored and readable, not committed
    bus_start();
    send_byte(8'hE4, 1'b1, "R2 address ack");
    send_byte(8'h01, 1'b1, "R4 data ack");
    bus_start();
    send_byte(8'hE5, 1'b1, "R8 read address ack after repeated START");
    recv_byte(1'b0, rb);
    chk("R8 read after repeated START", rb, 8'h01);
    chk("R8 chan_en held across repeated START", {6'd0, chan_en}, 8'h02);
    bus_stop();
    tick(5);
    chk("R8 commit at STOP", {6'd0, chan_en}, 8'h01);

    // R8 partial byte abandoned
    bus_start();
    send_byte(8'hE4, 1'b1, "R2 address ack");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hE5, 1'b1, "R8 address ack after abort");
    recv_byte(1'b0, rb);
    chk("R8 partial byte discarded", rb, 8'h01);
    bus_stop();
    tick(5);
    chk("R8 chan_en after aborted byte", {6'd0, chan_en}, 8'h01);

    // R6 readback format with live interrupts
    bus_start();
    send_byte(8'hE4, 1'b1, "R2 address ack");
    send_byte(8'hFD, 1'b1, "R4 data ack");
    bus_stop();
    tick(5);
    chk("R5 enables from low bits", {6'd0, chan_en}, 8'h01);
    irq_n = 2'b10;
    tick(5);
    bus_start();
    send_byte(8'hE5, 1'b1, "R2 read address ack");
    recv_byte(1'b0, rb);
    chk("R6 read with channel 0 interrupt", rb, 8'h1D);
    bus_stop();

    // R7 continued read, then release after NACK
    irq_n = 2'b00;
    tick(5);
    bus_start();
    send_byte(8'hE5, 1'b1, "R2 read address ack");
    recv_byte(1'b1, rb);
    chk("R6 read with both interrupts", rb, 8'h3D);
    recv_byte(1'b0, rb);
    chk("R7 second byte after master ACK", rb, 8'h3D);
    chk("R7 SDA released after NACK", {7'd0, drive}, 8'h00);
    bus_stop();
    irq_n = 2'b11;

    // R2 strap change, R3 old address ignored
    strap = 2'b01;
    tick(5);
    bus_start();
    send_byte(8'hE4, 1'b0, "R3 old address not acked");
    send_byte(8'h03, 1'b0, "R3 data ignored");
    bus_stop();
    tick(5);
    chk("R3 chan_en unchanged", {6'd0, chan_en}, 8'h01);
    bus_start();
    send_byte(8'hE2, 1'b1, "R2 strap address ack");
    send_byte(8'h02, 1'b1, "R4 data ack");
    bus_stop();
    tick(5);
    chk("R2 write via new strap", {6'd0, chan_en}, 8'h02);

    // R1 reset in mid-operation
    rst = 1'b1;
    tick(4);
    chk("R1 chan_en cleared", {6'd0, chan_en}, 8'h00);
    rst = 1'b0;
    tick(5);
    bus_start();
    send_byte(8'hE3, 1'b1, "R2 read address ack");
    recv_byte(1'b0, rb);
    chk("R1 register cleared", rb, 8'h00);
    bus_stop();
    tick(5);
    chk("R1 chan_en after idle STOP", {6'd0, chan_en}, 8'h00);

    finish_run();
  end

endmodule